// File: doc/BRIEF.md
# Multiphase Current Share Equalizer

This block keeps the phases of a multiphase buck converter carrying equal current. It takes one digitized current sample per phase in each switching period. When the period marker is asserted and every enabled phase has presented a valid sample, it works out the mean of the enabled phases' samples. It then forms, for each enabled phase, the signed difference between that mean and the phase's own sample.

Each difference passes through a per-phase first-order low-pass filter with a programmable shift. The filter result, clamped to the correction range, is the signed pulse-width trim applied to that phase. A phase with more current than the mean therefore receives a negative trim, and a phase below the mean receives a positive one. Phases that are switched off are left out of the mean, and their filters are held at zero. The mean is also presented as an output, because it measures total load demand.

Top module: `phase_balancer`

## Requirements
- R1: After reset, the average output and every correction output are zero.
- R2: The average and the filter states change only at a clock edge where `cyc_strobe` is high, `act_cnt` is nonzero, and `samp_vld` is set for every enabled phase. At all other edges they hold, apart from the clearing described in R6 and R7. New values are visible on the outputs after that edge.
- R3: With n = `act_cnt` (1 to 3), phases 0..n-1 are enabled. The average is (sum of their samples + floor(n/2)) / n in integer division, which rounds half up. With n = 1 the average equals the sample of phase 0. The average always lies between the smallest and the largest enabled sample.
- R4: For an enabled phase on an update, e = average − sample. The filter state becomes y + ((e − y) >>> K), where >>> is a flooring arithmetic shift and K = `filt_k`. With K = 0 the state becomes e.
- R5: The filter state, and with it the correction, saturates to the range −2^(CW−1) to 2^(CW−1)−1. With the defaults this is −512 to 511.
- R6: A phase whose index is not below `act_cnt` is disabled. From the next edge its correction reads zero. Its sample and its valid flag have no effect on the average or on whether an update happens.
- R7: With `act_cnt` = 0 no update occurs, all corrections are cleared, and the average holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_strobe | input | 1 | Switching-period marker, one clock wide |
| act_cnt | input | 2 | Number of enabled phases, 0 to 3 |
| samp | input | NCH*SW (36) | Unsigned current samples, phase i in bits [i*SW +: SW] |
| samp_vld | input | NCH (3) | Per-phase sample valid flags |
| filt_k | input | KW (3) | Filter shift K |
| corr | output | NCH*CW (30) | Signed per-phase corrections, phase i in bits [i*CW +: CW] |
| avg_out | output | SW (12) | Current cycle average |

## Verification
The hardest case to reach is a phase that is disabled but still drives a valid, extreme sample. At the same edge, an enabled phase withholds its valid flag, so the block must skip the update. The bench creates this case, and the opposite one, by switching `act_cnt` between strobes while it drives the samples and flags independently. It also drives a far-apart sample pair with K = 0 to push both lanes into saturation in the same period. An odd three-phase sum then checks the half-up rounding of the divide by three.

// File: rtl/pb_pkg.sv
package pb_pkg;
   // Number of enabled phases, as decoded from the count input.
   typedef enum logic [1:0] {
      PB_OFF   = 2'd0,
      PB_ONE   = 2'd1,
      PB_TWO   = 2'd2,
      PB_THREE = 2'd3
   } pb_mode_e;

   // Even shift for the divide-by-three reciprocal, so that 2^S mod 3 is 1.
   function automatic int recip_shift(input int sw);
      int s;
      s = sw + 3;
      if (s % 2 != 0) s = s + 1;
      return s;
   endfunction
endpackage

// File: rtl/pb_avg.sv
module pb_avg
   import pb_pkg::*;
#(
   parameter int NCH  = 3,
   parameter int SW   = 12,
   parameter int CNTW = 2
) (
   input  logic [NCH*SW-1:0] samp,
   input  logic [NCH-1:0]    act,
   input  logic [CNTW-1:0]   cnt,
   output logic [SW-1:0]     avg
);
   localparam int SUMW = SW + 2;
   localparam int DS   = recip_shift(SW);
   localparam int PW   = SUMW + 1 + DS;
   localparam logic [DS:0] RECIP = DS'(((64'd1 << DS) + 64'd2) / 64'd3);

   logic [SUMW-1:0] sum;
   logic [SUMW:0]   sum_r1;
   logic [SUMW:0]   half2;
   logic [SW-1:0]   q3;

   always_comb begin
      sum = '0;
      for (int i = 0; i < NCH; i++) begin
         if (act[i]) sum = sum + SUMW'(samp[i*SW +: SW]);
      end
   end

   assign sum_r1 = {1'b0, sum} + 1'b1;
   assign half2  = sum_r1 >> 1;

   generate
      if (NCH >= 3) begin : gen_div3
         logic [PW-1:0] prod;
         assign prod = PW'(sum_r1) * PW'(RECIP);
         assign q3   = prod[DS +: SW];
      end else begin : gen_nodiv3
         assign q3 = '0;
      end
   endgenerate

   generate
      if (NCH == 1) begin : gen_one
         assign avg = (cnt != '0) ? sum[SW-1:0] : '0;
      end else begin : gen_many
         always_comb begin
            case (pb_mode_e'(2'(cnt)))
               PB_TWO:   avg = half2[SW-1:0];
               PB_THREE: avg = q3;
               default:  avg = sum[SW-1:0];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/pb_lane.sv
module pb_lane #(
   parameter int SW = 12,
   parameter int CW = 10,
   parameter int KW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 upd,
   input  logic [SW-1:0]        avg,
   input  logic [SW-1:0]        samp,
   input  logic [KW-1:0]        k,
   output logic signed [CW-1:0] y
);
   localparam int EW   = SW + 2;
   localparam int BW   = (CW > EW) ? CW : EW;
   localparam int DW   = BW + 2;
   localparam int MAXI = (1 << (CW - 1)) - 1;
   localparam logic signed [DW-1:0] HI = DW'(MAXI);
   localparam logic signed [DW-1:0] LO = -HI - 1;

   logic signed [EW-1:0] err;
   logic signed [DW-1:0] err_x, y_x, diff, step, nxt;
   logic signed [CW-1:0] y_sat;

   assign err   = $signed({2'b00, avg}) - $signed({2'b00, samp});
   assign err_x = {{(DW-EW){err[EW-1]}}, err};
   assign y_x   = {{(DW-CW){y[CW-1]}}, y};
   assign diff  = err_x - y_x;
   assign step  = diff >>> k;
   assign nxt   = y_x + step;

   always_comb begin
      if (nxt > HI)      y_sat = HI[CW-1:0];
      else if (nxt < LO) y_sat = LO[CW-1:0];
      else               y_sat = nxt[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   y <= '0;
      else if (clr) y <= '0;
      else if (upd) y <= y_sat;
   end
endmodule

// File: rtl/phase_balancer.sv
module phase_balancer #(
   parameter int NCH  = 3,
   parameter int SW   = 12,
   parameter int CW   = 10,
   parameter int KW   = 3,
   parameter int CNTW = $clog2(NCH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_strobe,
   input  logic [CNTW-1:0]   act_cnt,
   input  logic [NCH*SW-1:0] samp,
   input  logic [NCH-1:0]    samp_vld,
   input  logic [KW-1:0]     filt_k,
   output logic [NCH*CW-1:0] corr,
   output logic [SW-1:0]     avg_out
);
   generate
      if (NCH < 1 || NCH > 3) begin : gen_bad_nch
         $error("phase_balancer: NCH must be 1 to 3");
      end
      if (SW < 2 || SW > 24) begin : gen_bad_sw
         $error("phase_balancer: SW must be 2 to 24");
      end
      if (CW < 2) begin : gen_bad_cw
         $error("phase_balancer: CW must be at least 2");
      end
   endgenerate

   logic [CNTW-1:0] eff_cnt;
   logic [NCH-1:0]  act;
   logic            all_ok;
   logic            upd;
   logic [SW-1:0]   avg_c;

   assign eff_cnt = (act_cnt > CNTW'(NCH)) ? CNTW'(NCH) : act_cnt;

   generate
      for (genvar i = 0; i < NCH; i++) begin : gen_act
         assign act[i] = (CNTW'(i) < eff_cnt);
      end
   endgenerate

   assign all_ok = (eff_cnt != '0) && ((samp_vld & act) == act);
   assign upd    = cyc_strobe && all_ok;

   pb_avg #(.NCH(NCH), .SW(SW), .CNTW(CNTW)) u_avg (
      .samp (samp),
      .act  (act),
      .cnt  (eff_cnt),
      .avg  (avg_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   avg_out <= '0;
      else if (upd) avg_out <= avg_c;
   end

   generate
      for (genvar i = 0; i < NCH; i++) begin : gen_lane
         logic signed [CW-1:0] y_i;
         pb_lane #(.SW(SW), .CW(CW), .KW(KW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!act[i]),
            .upd   (upd),
            .avg   (avg_c),
            .samp  (samp[i*SW +: SW]),
            .k     (filt_k),
            .y     (y_i)
         );
         assign corr[i*CW +: CW] = y_i;
      end
   endgenerate
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
   parameter int NCH  = 3,
   parameter int SW   = 12,
   parameter int CW   = 10,
   parameter int KW   = 3,
   parameter int CNTW = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_strobe,
   input logic [CNTW-1:0]   act_cnt,
   input logic [NCH*SW-1:0] samp,
   input logic [NCH-1:0]    samp_vld,
   input logic [KW-1:0]     filt_k,
   input logic [NCH*CW-1:0] corr,
   input logic [SW-1:0]     avg_out
);
   logic          fire;
   logic [SW-1:0] lo_s, hi_s;

   always_comb begin
      fire = cyc_strobe && (act_cnt != '0);
      lo_s = '1;
      hi_s = '0;
      for (int i = 0; i < NCH; i++) begin
         if (i < int'(act_cnt)) begin
            if (!samp_vld[i]) fire = 1'b0;
            if (samp[i*SW +: SW] < lo_s) lo_s = samp[i*SW +: SW];
            if (samp[i*SW +: SW] > hi_s) hi_s = samp[i*SW +: SW];
         end
      end
   end

   // R2: without a complete, strobed set of samples the average holds
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(avg_out));

   // R3: single phase passes its sample straight through
   assert_single_avg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act_cnt == CNTW'(1)) |=> (avg_out == $past(samp[SW-1:0])));

   // R3: average lies within the spread of the enabled samples
   assert_avg_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (avg_out >= $past(lo_s) && avg_out <= $past(hi_s)));

   // R4: K = 0 with one phase makes the error, and so the correction, zero
   assert_k0_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act_cnt == CNTW'(1) && filt_k == '0) |=> (corr[CW-1:0] == '0));

   generate
      for (genvar i = 0; i < NCH; i++) begin : gen_off
         // R6 and R7: a disabled phase reads zero correction from the next edge
         assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(act_cnt) <= i) |=> (corr[i*CW +: CW] == '0));
      end
   endgenerate
endmodule

bind phase_balancer pb_checker #(
   .NCH(NCH), .SW(SW), .CW(CW), .KW(KW), .CNTW(CNTW)
) u_chk (.*);

// File: tb/phase_balancer_tb.sv
module phase_balancer_tb;
   localparam int CLK_P = 10;
   localparam int NCH = 3;
   localparam int SW  = 12;
   localparam int CW  = 10;
   localparam int KW  = 3;
   localparam int CNTW = 2;
   localparam int HI = (1 << (CW - 1)) - 1;
   localparam int LO = -(1 << (CW - 1));

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cyc_strobe = 1'b0;
   logic [CNTW-1:0]   act_cnt = '0;
   logic [NCH*SW-1:0] samp = '0;
   logic [NCH-1:0]    samp_vld = '0;
   logic [KW-1:0]     filt_k = '0;
   logic [NCH*CW-1:0] corr;
   logic [SW-1:0]     avg_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int m_avg = 0;
   int m_y[NCH] = '{0, 0, 0};

   int    q_avg[$];
   int    q_c0[$];
   int    q_c1[$];
   int    q_c2[$];
   string q_tag[$];

   always #(CLK_P/2) clk = ~clk;

   phase_balancer #(.NCH(NCH), .SW(SW), .CW(CW), .KW(KW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .act_cnt(act_cnt),
      .samp(samp), .samp_vld(samp_vld), .filt_k(filt_k),
      .corr(corr), .avg_out(avg_out)
   );

   function automatic int corr_of(input int i);
      logic signed [CW-1:0] v;
      v = corr[i*CW +: CW];
      return int'(v);
   endfunction

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic drive(input int cnt, input int s0, input int s1, input int s2,
                        input logic [2:0] vld, input bit stb, input int k,
                        input string tag);
      int s[NCH];
      bit ok;
      int sum;
      @(negedge clk);
      s[0] = s0; s[1] = s1; s[2] = s2;
      act_cnt    = CNTW'(cnt);
      samp       = {SW'(s2), SW'(s1), SW'(s0)};
      samp_vld   = vld;
      cyc_strobe = stb;
      filt_k     = KW'(k);
      ok = stb && (cnt != 0);
      for (int i = 0; i < cnt; i++) if (!vld[i]) ok = 1'b0;
      if (ok) begin
         sum = 0;
         for (int i = 0; i < cnt; i++) sum += s[i];
         m_avg = (sum + cnt / 2) / cnt;
         for (int i = 0; i < cnt; i++) begin
            int e, d;
            e = m_avg - s[i];
            d = (e - m_y[i]) >>> k;
            m_y[i] = m_y[i] + d;
            if (m_y[i] > HI) m_y[i] = HI;
            if (m_y[i] < LO) m_y[i] = LO;
         end
      end
      for (int i = cnt; i < NCH; i++) m_y[i] = 0;
      q_avg.push_back(m_avg);
      q_c0.push_back(m_y[0]);
      q_c1.push_back(m_y[1]);
      q_c2.push_back(m_y[2]);
      q_tag.push_back(tag);
   endtask

   // Monitor: compares the outputs just after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_tag.size() > 0) begin
            int ea, e0, e1, e2;
            string t;
            ea = q_avg.pop_front();
            e0 = q_c0.pop_front();
            e1 = q_c1.pop_front();
            e2 = q_c2.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (int'(avg_out) != ea || corr_of(0) != e0 || corr_of(1) != e1 ||
                corr_of(2) != e2) begin
               failures++;
               $display("FAIL %s: got avg=%0d corr=%0d,%0d,%0d expected avg=%0d corr=%0d,%0d,%0d",
                        t, avg_out, corr_of(0), corr_of(1), corr_of(2), ea, e0, e1, e2);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int lfsr;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (avg_out != '0 || corr != '0) begin
         failures++;
         $display("FAIL R1: got avg=%0d corr=%0h expected avg=0 corr=0", avg_out, corr);
      end
      rst_n = 1'b1;

      drive(3, 100, 200, 300, 3'b111, 1, 0, "R3 R4 three phases K0");
      drive(3, 1000, 1003, 1001, 3'b111, 1, 2, "R3 divide-by-three rounding");
      drive(3, 50, 60, 70, 3'b101, 1, 1, "R2 missing valid holds");
      drive(3, 50, 60, 70, 3'b111, 0, 1, "R2 no strobe holds");
      drive(3, 50, 60, 70, 3'b111, 1, 1, "R4 filter step K1");
      drive(2, 10, 13, 4095, 3'b111, 0, 1, "R6 phase 2 cleared without strobe");
      drive(2, 10, 13, 4095, 3'b111, 1, 0, "R3 R6 two phases round half up");
      drive(2, 20, 30, 4095, 3'b011, 1, 0, "R6 disabled valid ignored");
      drive(1, 777, 0, 0, 3'b001, 1, 0, "R3 single phase average");
      drive(2, 0, 4095, 9, 3'b011, 1, 0, "R5 saturation both limits");
      drive(2, 4095, 0, 9, 3'b011, 1, 3, "R5 R4 shift from limit");
      drive(0, 5, 6, 7, 3'b111, 1, 0, "R7 zero count clears and holds");
      drive(3, 4095, 4095, 4095, 3'b111, 1, 0, "R3 full-scale three phases");
      drive(3, 0, 4095, 4095, 3'b111, 1, 0, "R5 R3 wide spread");

      lfsr = 32'h1234567;
      for (int n = 0; n < 300; n++) begin
         int a, b, c, cn, kk;
         logic [2:0] v;
         lfsr = lfsr * 1103515245 + 12345;
         a = (lfsr >>> 4) & 4095;
         lfsr = lfsr * 1103515245 + 12345;
         b = (lfsr >>> 4) & 4095;
         lfsr = lfsr * 1103515245 + 12345;
         c  = (lfsr >>> 4) & 4095;
         cn = (lfsr >>> 20) & 3;
         kk = (lfsr >>> 23) & 7;
         v  = ((lfsr >>> 27) & 7) == 0 ? 3'b110 : 3'b111;
         drive(cn, a, b, c, v, ((lfsr >>> 17) & 3) != 0, kk, "R2 R3 R4 R5 R6 random period");
      end

      @(negedge clk);
      cyc_strobe = 1'b0;
      while (q_tag.size() > 0) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule